// File: doc/BRIEF.md
# Four-Phase PHY Register Writer

This block is the master for a parallel configuration port that reaches registers inside the SerDes PHYs. It serves several PHY instances (two by default). A shared address and data bus runs to every PHY, while each PHY has its own port-select, write-enable and acknowledge lines. Each write is a full four-phase exchange. The block drives address and data, raises write-enable, and waits for acknowledge to rise. It then drops write-enable and waits for acknowledge to fall. Each of the two waits has its own cycle-count timeout. When a wait expires, the block raises a warning flag and moves on to the next step. It does not abort.

Software or a boot sequencer can start two kinds of operation. A single request carries a PHY index, a 16-bit address and a 16-bit data word. A built-in burst writes the lane initialisation word into every lane register of every PHY. The first operation after reset asserts port-select on all PHYs. It then waits a settle period before the first write-enable. Port-select stays high after that, so later operations skip the settle wait. Each operation ends with a one-cycle done pulse.

Top module: `phy_cfg_writer`

## Requirements
- R1: After reset, busy, done, warn, every port_sel bit and every port_wen bit are low.
- R2: The first accepted operation raises port_sel on all PHYs together. No write-enable rises until port_sel has been high for at least SETTLE_CYC cycles. Port_sel then stays high.
- R3: While a write-enable is high, port_addr and port_wdata hold steady.
- R4: Write-enable stays high until the acknowledge of the same PHY is seen high. It is low in the next cycle. With a responder that raises ack D cycles after write-enable, write-enable is high for D+1 cycles.
- R5: A following write-enable is raised only after the acknowledge of the previous write has been seen low.
- R6: If acknowledge does not rise, write-enable is held for exactly TMO_CYC cycles and then dropped. Warn is set and the operation still completes.
- R7: If acknowledge does not fall after write-enable drops, the block waits TMO_CYC cycles, sets warn and completes.
- R8: Only the PHY named by the current write sees write-enable. Every other port_wen bit stays low.
- R9: A burst performs NUM_PHY*LANES writes. It covers PHY 0 lanes 0..3 and then PHY 1 lanes 0..3. Each write uses address 0x1008 + 0x100*lane and data 0x0E21 (bits 0, 5, 9, 10 and 11 set).
- R10: Done is high for exactly one cycle after the last acknowledge falls, and busy is low in the next cycle. Warn clears when the next operation is accepted.
- R11: When burst_start and req_valid arrive in the same idle cycle, the burst wins and the single request is dropped. Requests that arrive while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a single write (sampled while idle) |
| req_phy | input | PHY_W | Target PHY of the single write |
| req_addr | input | ADDR_W | Register address of the single write |
| req_data | input | DATA_W | Data of the single write |
| burst_start | input | 1 | Start the lane initialisation burst |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| warn | output | 1 | An acknowledge wait timed out during the last operation |
| port_sel | output | NUM_PHY | Port select, one per PHY |
| port_addr | output | ADDR_W | Shared register address |
| port_wdata | output | DATA_W | Shared write data |
| port_wen | output | NUM_PHY | Write-enable, one per PHY |
| port_ack | input | NUM_PHY | Acknowledge, one per PHY |

## Verification
The bound checker watches four things on every cycle. At most one write-enable may be high, and only while every select is high. Address and data must stay steady while write-enable is high. Write-enable must drop the cycle after a matching acknowledge, and it may not stay high longer than the rise timeout. Done must be a single pulse followed by idle. Other behaviour depends on the responder and the sequence of operations, so only the bench scenarios can show it. The bench checks the settle gap before the first write, the exact burst order and addresses, and the write-enable length for each ack delay. It also checks warn behaviour with acknowledge stuck low or stuck high, and which of two simultaneous starts wins.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;
   typedef enum logic [2:0] {
      HS_IDLE   = 3'd0,
      HS_SETTLE = 3'd1,
      HS_SETUP  = 3'd2,
      HS_RISE   = 3'd3,
      HS_FALL   = 3'd4
   } hs_state_t;
endpackage

// File: rtl/phycfg_item_src.sv
module phycfg_item_src #(
   parameter int NUM_PHY     = 2,
   parameter int LANES       = 4,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int LANE_BASE   = 32'h1008,
   parameter int LANE_STRIDE = 32'h100,
   parameter int INIT_VAL    = 32'h0E21,
   localparam int PHY_W      = $clog2(NUM_PHY),
   localparam int LANE_W     = $clog2(LANES),
   localparam int IDX_W      = $clog2(NUM_PHY * LANES)
) (
   input  logic              is_burst,
   input  logic [IDX_W-1:0]  idx,
   input  logic [PHY_W-1:0]  one_phy,
   input  logic [ADDR_W-1:0] one_addr,
   input  logic [DATA_W-1:0] one_data,
   output logic [PHY_W-1:0]  item_phy,
   output logic [ADDR_W-1:0] item_addr,
   output logic [DATA_W-1:0] item_data
);
   logic [LANE_W-1:0] lane;
   logic [PHY_W-1:0]  bphy;

   assign lane = idx[LANE_W-1:0];
   assign bphy = PHY_W'(idx >> LANE_W);

   always_comb begin
      if (is_burst) begin
         item_phy  = bphy;
         item_addr = ADDR_W'(LANE_BASE) + ADDR_W'(lane) * ADDR_W'(LANE_STRIDE);
         item_data = DATA_W'(INIT_VAL);
      end else begin
         item_phy  = one_phy;
         item_addr = one_addr;
         item_data = one_data;
      end
   end
endmodule

// File: rtl/phycfg_hs_engine.sv
module phycfg_hs_engine
   import phycfg_pkg::*;
#(
   parameter int SETTLE_CYC = 10,
   parameter int TMO_CYC    = 500,
   localparam int MAXC      = (SETTLE_CYC > TMO_CYC) ? SETTLE_CYC : TMO_CYC,
   localparam int CNT_W     = $clog2(MAXC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic need_settle,
   input  logic ack,
   output logic wen_act,
   output logic item_done,
   output logic tmo
);
   hs_state_t        st;
   logic [CNT_W-1:0] cnt;
   logic             settle_end, tmo_end;

   assign settle_end = (cnt == CNT_W'(SETTLE_CYC - 1));
   assign tmo_end    = (cnt == CNT_W'(TMO_CYC - 1));

   assign wen_act   = (st == HS_RISE);
   assign item_done = (st == HS_FALL) && (!ack || tmo_end);
   assign tmo       = ((st == HS_RISE) && !ack && tmo_end) ||
                      ((st == HS_FALL) &&  ack && tmo_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= HS_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            HS_IDLE: begin
               cnt <= '0;
               if (go) st <= need_settle ? HS_SETTLE : HS_SETUP;
            end
            HS_SETTLE: begin
               if (settle_end) begin
                  st  <= HS_SETUP;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            HS_SETUP: begin
               st  <= HS_RISE;
               cnt <= '0;
            end
            HS_RISE: begin
               if (ack || tmo_end) begin
                  st  <= HS_FALL;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            HS_FALL: begin
               if (!ack || tmo_end) begin
                  st  <= HS_IDLE;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            default: begin
               st  <= HS_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/phycfg_wen_fan.sv
module phycfg_wen_fan #(
   parameter int NUM_PHY = 2,
   localparam int PHY_W  = $clog2(NUM_PHY)
) (
   input  logic               wen_act,
   input  logic [PHY_W-1:0]   cur_phy,
   input  logic [NUM_PHY-1:0] ack_in,
   output logic [NUM_PHY-1:0] wen_out,
   output logic               ack_sel
);
   for (genvar p = 0; p < NUM_PHY; p++) begin : g_lane
      assign wen_out[p] = wen_act && (cur_phy == PHY_W'(p));
   end
   assign ack_sel = ack_in[cur_phy];
endmodule

// File: rtl/phy_cfg_writer.sv
module phy_cfg_writer #(
   parameter int NUM_PHY     = 2,
   parameter int LANES       = 4,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SETTLE_CYC  = 10,
   parameter int TMO_CYC     = 500,
   parameter int LANE_BASE   = 32'h1008,
   parameter int LANE_STRIDE = 32'h100,
   parameter int INIT_VAL    = 32'h0E21,
   localparam int PHY_W      = $clog2(NUM_PHY),
   localparam int IDX_W      = $clog2(NUM_PHY * LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [PHY_W-1:0]   req_phy,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_data,
   input  logic               burst_start,
   output logic               busy,
   output logic               done,
   output logic               warn,
   output logic [NUM_PHY-1:0] port_sel,
   output logic [ADDR_W-1:0]  port_addr,
   output logic [DATA_W-1:0]  port_wdata,
   output logic [NUM_PHY-1:0] port_wen,
   input  logic [NUM_PHY-1:0] port_ack
);
   localparam int LAST_IDX = NUM_PHY * LANES - 1;

   if (NUM_PHY < 2) begin : g_chk_phy
      $error("NUM_PHY must be at least 2");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_chk_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (SETTLE_CYC < 1 || TMO_CYC < 2) begin : g_chk_cyc
      $error("SETTLE_CYC must be >= 1 and TMO_CYC >= 2");
   end

   logic              busy_q, fin_q, go_q, burst_q, settle_q, sel_q, warn_q;
   logic [IDX_W-1:0]  idx_q;
   logic [PHY_W-1:0]  rphy_q;
   logic [ADDR_W-1:0] raddr_q;
   logic [DATA_W-1:0] rdata_q;
   logic [PHY_W-1:0]  cur_phy;
   logic              wen_act, item_done, tmo, ack_sel, last_item;

   phycfg_item_src #(
      .NUM_PHY(NUM_PHY), .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .LANE_BASE(LANE_BASE), .LANE_STRIDE(LANE_STRIDE), .INIT_VAL(INIT_VAL)
   ) u_src (
      .is_burst (burst_q),
      .idx      (idx_q),
      .one_phy  (rphy_q),
      .one_addr (raddr_q),
      .one_data (rdata_q),
      .item_phy (cur_phy),
      .item_addr(port_addr),
      .item_data(port_wdata)
   );

   phycfg_hs_engine #(
      .SETTLE_CYC(SETTLE_CYC), .TMO_CYC(TMO_CYC)
   ) u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go_q),
      .need_settle(settle_q),
      .ack        (ack_sel),
      .wen_act    (wen_act),
      .item_done  (item_done),
      .tmo        (tmo)
   );

   phycfg_wen_fan #(.NUM_PHY(NUM_PHY)) u_fan (
      .wen_act(wen_act),
      .cur_phy(cur_phy),
      .ack_in (port_ack),
      .wen_out(port_wen),
      .ack_sel(ack_sel)
   );

   assign last_item = !burst_q || (idx_q == IDX_W'(LAST_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         fin_q    <= 1'b0;
         go_q     <= 1'b0;
         burst_q  <= 1'b0;
         settle_q <= 1'b0;
         sel_q    <= 1'b0;
         warn_q   <= 1'b0;
         idx_q    <= '0;
         rphy_q   <= '0;
         raddr_q  <= '0;
         rdata_q  <= '0;
      end else begin
         go_q  <= 1'b0;
         fin_q <= 1'b0;
         if (!busy_q) begin
            if (burst_start || req_valid) begin
               busy_q   <= 1'b1;
               burst_q  <= burst_start;
               idx_q    <= '0;
               warn_q   <= 1'b0;
               sel_q    <= 1'b1;
               settle_q <= !sel_q;
               go_q     <= 1'b1;
               if (!burst_start) begin
                  rphy_q  <= req_phy;
                  raddr_q <= req_addr;
                  rdata_q <= req_data;
               end
            end
         end else begin
            if (tmo) warn_q <= 1'b1;
            if (item_done) begin
               settle_q <= 1'b0;
               if (last_item) fin_q <= 1'b1;
               else begin
                  idx_q <= idx_q + 1'b1;
                  go_q  <= 1'b1;
               end
            end
            if (fin_q) busy_q <= 1'b0;
         end
      end
   end

   assign busy     = busy_q;
   assign done     = fin_q;
   assign warn     = warn_q;
   assign port_sel = {NUM_PHY{sel_q}};
endmodule

// File: rtl/phy_cfg_writer_chk.sv
module phy_cfg_writer_chk #(
   parameter int NUM_PHY = 2,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int TMO_CYC = 500,
   localparam int HC_W   = $clog2(TMO_CYC + 2)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_PHY-1:0] port_sel,
   input logic [NUM_PHY-1:0] port_wen,
   input logic [NUM_PHY-1:0] port_ack,
   input logic [ADDR_W-1:0]  port_addr,
   input logic [DATA_W-1:0]  port_wdata,
   input logic               done,
   input logic               busy
);
   logic [HC_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_cnt <= '0;
      else if (|port_wen) begin
         if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      end else hi_cnt <= '0;
   end

   p_wen_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_wen));

   p_sel_before_wen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|port_wen) |-> (&port_sel));

   p_bus_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|port_wen) && $past(|port_wen)) |-> ($stable(port_addr) && $stable(port_wdata)));

   p_drop_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(port_wen & port_ack)) |=> !(|port_wen));

   p_rise_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|port_wen) |-> (hi_cnt < HC_W'(TMO_CYC)));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_done_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

bind phy_cfg_writer phy_cfg_writer_chk #(
   .NUM_PHY(NUM_PHY), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_CYC(TMO_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .port_sel  (port_sel),
   .port_wen  (port_wen),
   .port_ack  (port_ack),
   .port_addr (port_addr),
   .port_wdata(port_wdata),
   .done      (done),
   .busy      (busy)
);

// File: tb/sim_phy_cfg_writer.sv
module sim_phy_cfg_writer;
   localparam int SETTLE = 10;
   localparam int TMO    = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [0:0]  req_phy = '0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_data = '0;
   logic        burst_start = 1'b0;
   logic        busy, done, warn;
   logic [1:0]  port_sel, port_wen, port_ack;
   logic [15:0] port_addr, port_wdata;

   always #2 clk = ~clk;

   phy_cfg_writer #(.SETTLE_CYC(SETTLE), .TMO_CYC(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_phy(req_phy),
      .req_addr(req_addr), .req_data(req_data), .burst_start(burst_start),
      .busy(busy), .done(done), .warn(warn), .port_sel(port_sel),
      .port_addr(port_addr), .port_wdata(port_wdata), .port_wen(port_wen),
      .port_ack(port_ack)
   );

   // responder: mode 0 = ack follows wen after dly cycles, 1 = stuck low, 2 = stuck high
   int         mode [2];
   int         dly  [2];
   logic [3:0] pipe [2];

   initial begin
      mode[0] = 0; mode[1] = 0; dly[0] = 1; dly[1] = 1;
      pipe[0] = '0; pipe[1] = '0;
   end

   always @(posedge clk) begin
      pipe[0] <= {pipe[0][2:0], port_wen[0]};
      pipe[1] <= {pipe[1][2:0], port_wen[1]};
   end

   always_comb begin
      for (int p = 0; p < 2; p++)
         port_ack[p] = (mode[p] == 2) ? 1'b1 :
                       (mode[p] == 0) ? pipe[p][dly[p]-1] : 1'b0;
   end

   int n_chk = 0, n_bad = 0, mon_chk = 0, mon_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // write monitor
   int          log_n = 0;
   int          log_phy  [64];
   logic [15:0] log_addr [64];
   logic [15:0] log_data [64];
   logic [1:0]  prev_wen = '0;
   int          hi_len [2];
   bit          unstable [2];
   logic [15:0] held_a, held_d;

   always @(negedge clk) begin
      for (int p = 0; p < 2; p++) begin
         if (port_wen[p] && !prev_wen[p]) begin
            if (log_n < 64) begin
               log_phy[log_n]  = p;
               log_addr[log_n] = port_addr;
               log_data[log_n] = port_wdata;
            end
            log_n++;
            mon_chk++;
            if (port_wen[1-p]) begin
               mon_bad++;
               $display("FAIL R8: actual %0h expected %0h", port_wen, 2'b1 << p);
            end
            if (mode[p] == 0) begin
               mon_chk++;
               if (port_ack[p]) begin
                  mon_bad++;
                  $display("FAIL R5: actual %0h expected %0h", port_ack[p], 0);
               end
            end
            hi_len[p]   = 1;
            unstable[p] = 1'b0;
            held_a = port_addr;
            held_d = port_wdata;
         end else if (port_wen[p]) begin
            hi_len[p]++;
            if (port_addr != held_a || port_wdata != held_d) unstable[p] = 1'b1;
         end else if (prev_wen[p]) begin
            int exp_len;
            exp_len = (mode[p] == 0) ? dly[p] + 1 : (mode[p] == 1) ? TMO : 1;
            mon_chk++;
            if (hi_len[p] != exp_len) begin
               mon_bad++;
               $display("FAIL R4/R6: actual %0d expected %0d", hi_len[p], exp_len);
            end
            mon_chk++;
            if (unstable[p]) begin
               mon_bad++;
               $display("FAIL R3: actual %0h expected %0h", 1, 0);
            end
         end
      end
      prev_wen = port_wen;
   end

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, req, done, 1);
      @(negedge clk);
      chk(!done && !busy, "R10", {done, busy}, 0);
   endtask

   task automatic single(input int ph, input logic [15:0] a, input logic [15:0] d,
                         input bit exp_warn, input string req);
      int base = log_n;
      @(negedge clk);
      req_valid = 1'b1; req_phy = ph[0]; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R10", busy, 1);
      wait_done(req);
      chk(log_n == base + 1, req, log_n, base + 1);
      chk(log_phy[base] == ph && log_addr[base] == a && log_data[base] == d, req,
          {log_addr[base], log_data[base]}, {a, d});
      chk(warn == exp_warn, req, warn, exp_warn);
   endtask

   task automatic check_burst(input int base, input string req);
      chk(log_n == base + 8, req, log_n, base + 8);
      for (int i = 0; i < 8; i++) begin
         logic [15:0] ea;
         ea = 16'h1008 + 16'h0100 * 16'(i % 4);
         chk(log_phy[base+i] == i / 4 && log_addr[base+i] == ea && log_data[base+i] == 16'h0E21,
             req, {log_addr[base+i], log_data[base+i]}, {ea, 16'h0E21});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                  n_chk + mon_chk + 1, n_bad + mon_bad + 1);
         $finish;
      end
   end

   initial begin
      int t_sel, t_wen, base, n;
      logic [15:0] pats [4];
      pats[0] = 16'h0001; pats[1] = 16'h8000; pats[2] = 16'hA5A5; pats[3] = 16'hFFFF;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !warn && port_sel == 2'b00 && port_wen == 2'b00, "R1",
          {busy, done, warn, port_sel, port_wen}, 0);

      // R2 first operation: select rises, settle gap before first write-enable
      base = log_n;
      req_valid = 1'b1; req_phy = 1'b0; req_addr = 16'h1234; req_data = 16'h5678;
      @(negedge clk);
      req_valid = 1'b0;
      t_sel = -1; t_wen = -1; n = 0;
      while (t_wen < 0 && n < 200) begin
         if (t_sel < 0 && port_sel == 2'b11) t_sel = n;
         if (port_wen != 2'b00) t_wen = n;
         @(negedge clk);
         n++;
      end
      chk(t_sel >= 0 && t_wen - t_sel >= SETTLE, "R2", t_wen - t_sel, SETTLE);
      wait_done("R10");
      chk(log_n == base + 1 && log_addr[base] == 16'h1234, "R2", log_addr[base], 16'h1234);
      chk(port_sel == 2'b11, "R2", port_sel, 2'b11);

      // sweep: both PHYs, ack delays 1..3, several data/address patterns
      for (int ph = 0; ph < 2; ph++)
         for (int d = 1; d <= 3; d++)
            for (int k = 0; k < 4; k++) begin
               dly[ph] = d;
               single(ph, pats[k] ^ 16'(d), ~pats[k], 1'b0, "R4");
            end
      dly[0] = 1; dly[1] = 2;

      // R9 burst
      base = log_n;
      @(negedge clk);
      burst_start = 1'b1;
      @(negedge clk);
      burst_start = 1'b0;
      wait_done("R9");
      check_burst(base, "R9");
      chk(warn == 1'b0, "R9", warn, 0);

      // R6 acknowledge never rises on PHY 1
      mode[1] = 1;
      single(1, 16'h00AA, 16'h0055, 1'b1, "R6");
      mode[1] = 0;
      // R10 warn clears on next accept
      single(1, 16'h00AB, 16'h0056, 1'b0, "R10");

      // R7 acknowledge never falls on PHY 0
      mode[0] = 2;
      single(0, 16'h0F0F, 16'hF0F0, 1'b1, "R7");
      mode[0] = 0;
      single(0, 16'h0F10, 16'hF0F1, 1'b0, "R10");

      // R11 simultaneous start: burst wins; requests while busy are ignored
      base = log_n;
      @(negedge clk);
      burst_start = 1'b1; req_valid = 1'b1; req_phy = 1'b1;
      req_addr = 16'hDEAD; req_data = 16'hBEEF;
      @(negedge clk);
      burst_start = 1'b0; req_valid = 1'b0;
      repeat (20) @(negedge clk);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done("R11");
      check_burst(base, "R11");
      repeat (10) @(negedge clk);
      chk(log_n == base + 8 && !busy, "R11", log_n, base + 8);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
               n_chk + mon_chk, n_bad + mon_bad);
      $finish;
   end
endmodule